// File: doc/BRIEF.md
# In-Order Retirement Window

This block keeps track of the instructions an out-of-order core has in flight. The issue stage claims one slot per instruction in program order and records the destination tag and whether the instruction is a branch. Functional units report results by slot number, in any order. Each report is also driven onto a result bus at once, so that operand-waiting stations can pick up the value. The oldest slot retires only after its result has arrived. At most one slot retires per cycle.

A branch result carries a mispredict flag and the correct target address. When a mispredicted branch becomes the oldest slot, it retires. In the same cycle the block raises a redirect with the correct address and drops every younger slot. Results behind a branch therefore never reach architectural state until that branch has retired as correctly predicted. The depth is a parameter with a default of 16 and must be a power of two. The head and tail pointers each carry one wrap bit beyond the slot index.

Top module: `retire_window`

## Requirements
- R1: After reset the window is empty: `alloc_ready` is 1, `alloc_idx` is 0, and `commit_valid` and `redirect_valid` are 0.
- R2: Each accepted allocation (`alloc_valid` and `alloc_ready` both high at a rising edge) takes slot `alloc_idx`. `alloc_idx` then advances by one, modulo DEPTH, and it holds while nothing is accepted and no redirect occurs.
- R3: With DEPTH slots occupied, `alloc_ready` is 0 and a raised `alloc_valid` has no effect: nothing is stored and `alloc_idx` does not move.
- R4: Results may be written back in any order. `commit_valid` is raised only for the oldest occupied slot, and only in the cycles after its result was written back, so `commit_dest` values appear in allocation order, one per cycle.
- R5: A write-back to an occupied slot raises `bcast_valid` in the same cycle, with `bcast_dest` equal to that slot's recorded destination tag and `bcast_value` equal to `wb_value`.
- R6: When the oldest slot is a branch whose write-back had `wb_mispredict` set, the block raises `commit_valid` and `redirect_valid` together in one cycle, with `redirect_pc` equal to that write-back's `wb_target`, and holds `alloc_ready` at 0. In the next cycle the window is empty and `alloc_idx` is the branch's slot plus one.
- R7: A branch written back with `wb_mispredict` at 0 retires without a redirect, and the slots behind it retire normally.
- R8: A write-back to a slot that is not occupied, for example one discarded by a redirect, is ignored: `bcast_valid` stays 0 and no commit follows.
- R9: Allocation and retirement can happen in the same cycle, leaving the occupancy unchanged. A retirement from a full window frees a slot only from the following cycle on.
- R10: `wb_mispredict` on a slot not marked as a branch is ignored, and that slot retires without a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Issue side requests a slot |
| alloc_dest | input | TAG_W | Destination tag of the new instruction |
| alloc_is_br | input | 1 | New instruction is a branch |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation receives |
| wb_valid | input | 1 | A functional unit reports a result |
| wb_idx | input | log2(DEPTH) | Slot the result belongs to |
| wb_value | input | DATA_W | Result value |
| wb_mispredict | input | 1 | Branch outcome differed from the prediction |
| wb_target | input | PC_W | Correct fetch address for a branch |
| bcast_valid | output | 1 | Result bus carries a value |
| bcast_dest | output | TAG_W | Tag of the value on the result bus |
| bcast_value | output | DATA_W | Value on the result bus |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_dest | output | TAG_W | Tag of the retiring slot |
| commit_value | output | DATA_W | Value of the retiring slot |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | PC_W | Correct fetch address |

## Verification
Two pairs of events can fall in the same cycle: a retirement with an allocation, and a mispredict retirement with an allocation attempt. To provoke the first, the bench fills the window and then retires one slot. It checks that `alloc_ready` stays low during that retiring cycle and rises only afterwards. It then offers a new allocation in the same cycle as the next retirement and checks from the later commit sequence that both took effect. To provoke the second, the bench holds `alloc_valid` high in the cycle the redirect fires. It checks that the window is empty afterwards, and that the instruction offered with the redirect never commits.

// File: rtl/retire_window_pkg.sv
// Shared types for the in-order retirement window.
// Assumes nothing beyond a packed flag group per slot.
package retire_window_pkg;

    // Per-slot status bits
    typedef struct packed {
        logic live;   // slot holds an instruction in flight
        logic done;   // result has been written back
        logic is_br;  // instruction is a branch
        logic bad;    // branch was mispredicted
    } rw_flags_t;

endpackage

// File: rtl/rw_pointers.sv
// Head/tail pointer pair for a circular window of DEPTH slots.
// Each pointer has one wrap bit above the slot index, so equal indices
// with differing wrap bits mean full. A flush makes the window empty just
// past the retiring head. Assumes DEPTH is a power of two and at least 2,
// and that flush is only raised together with a pop.
module rw_pointers #(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic                         flush,
    output logic [$clog2(DEPTH)-1:0]     head_idx,
    output logic [$clog2(DEPTH)-1:0]     tail_idx,
    output logic                         full,
    output logic                         empty
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W:0] STEP = 1;

    logic [IDX_W:0] head_q;
    logic [IDX_W:0] tail_q;

    // Advance the pointers; a flush collapses both to the slot after the head
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (flush) begin
            head_q <= head_q + STEP;
            tail_q <= head_q + STEP;
        end else begin
            if (push) tail_q <= tail_q + STEP;
            if (pop)  head_q <= head_q + STEP;
        end
    end

    // Derive slot indices and occupancy state
    always_comb begin
        head_idx = head_q[IDX_W-1:0];
        tail_idx = tail_q[IDX_W-1:0];
        empty    = (head_q == tail_q);
        full     = (head_q[IDX_W] != tail_q[IDX_W]) &&
                   (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);
    end

endmodule

// File: rtl/rw_slots.sv
// Slot storage for the retirement window: flags, destination tag, result
// and correct target per slot. It has two read ports, one for the head
// slot and one for the slot being written back. A write-back to a slot
// that is not live is dropped. Assumes alloc and retire never name the
// same slot in one cycle, which full/empty gating in the parent guarantees.
module rw_slots
    import retire_window_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_we,
    input  logic [$clog2(DEPTH)-1:0]  alloc_slot,
    input  logic [TAG_W-1:0]          alloc_dest,
    input  logic                      alloc_is_br,
    input  logic                      wb_we,
    input  logic [$clog2(DEPTH)-1:0]  wb_slot,
    input  logic [DATA_W-1:0]         wb_value,
    input  logic                      wb_bad,
    input  logic [PC_W-1:0]           wb_target,
    input  logic                      retire_we,
    input  logic [$clog2(DEPTH)-1:0]  retire_slot,
    input  logic                      flush,
    input  logic [$clog2(DEPTH)-1:0]  head_slot,
    output logic                      head_live,
    output logic                      head_done,
    output logic                      head_bad,
    output logic [TAG_W-1:0]          head_dest,
    output logic [DATA_W-1:0]         head_value,
    output logic [PC_W-1:0]           head_target,
    output logic                      wbq_live,
    output logic [TAG_W-1:0]          wbq_dest
);
    rw_flags_t         flg    [DEPTH];
    logic [TAG_W-1:0]  dest   [DEPTH];
    logic [DATA_W-1:0] value  [DEPTH];
    logic [PC_W-1:0]   target [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Update one slot: allocate, write back, retire or flush
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flg[i]    <= '0;
                dest[i]   <= '0;
                value[i]  <= '0;
                target[i] <= '0;
            end else if (flush) begin
                flg[i].live <= 1'b0;
            end else begin
                if (alloc_we && alloc_slot == i) begin
                    flg[i].live  <= 1'b1;
                    flg[i].done  <= 1'b0;
                    flg[i].is_br <= alloc_is_br;
                    flg[i].bad   <= 1'b0;
                    dest[i]      <= alloc_dest;
                end else if (retire_we && retire_slot == i) begin
                    flg[i].live  <= 1'b0;
                end
                if (wb_we && wb_slot == i && flg[i].live) begin
                    flg[i].done <= 1'b1;
                    flg[i].bad  <= wb_bad & flg[i].is_br;
                    value[i]    <= wb_value;
                    target[i]   <= wb_target;
                end
            end
        end
    end

    // Read the head slot and the slot addressed by the write-back
    always_comb begin
        head_live   = flg[head_slot].live;
        head_done   = flg[head_slot].done;
        head_bad    = flg[head_slot].bad;
        head_dest   = dest[head_slot];
        head_value  = value[head_slot];
        head_target = target[head_slot];
        wbq_live    = flg[wb_slot].live;
        wbq_dest    = dest[wb_slot];
    end

endmodule

// File: rtl/retire_window.sv
// In-order retirement window. It takes slots in program order, accepts
// results out of order, puts each result on the result bus, and retires
// the oldest slot once it is done. A mispredicted branch at the head
// retires, raises a redirect and empties the window. Assumes DEPTH is a
// power of two.
module retire_window #(
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_valid,
    input  logic [TAG_W-1:0]          alloc_dest,
    input  logic                      alloc_is_br,
    output logic                      alloc_ready,
    output logic [$clog2(DEPTH)-1:0]  alloc_idx,
    input  logic                      wb_valid,
    input  logic [$clog2(DEPTH)-1:0]  wb_idx,
    input  logic [DATA_W-1:0]         wb_value,
    input  logic                      wb_mispredict,
    input  logic [PC_W-1:0]           wb_target,
    output logic                      bcast_valid,
    output logic [TAG_W-1:0]          bcast_dest,
    output logic [DATA_W-1:0]         bcast_value,
    output logic                      commit_valid,
    output logic [TAG_W-1:0]          commit_dest,
    output logic [DATA_W-1:0]         commit_value,
    output logic                      redirect_valid,
    output logic [PC_W-1:0]           redirect_pc
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] tail_idx;
    logic             full;
    logic             empty;
    logic             alloc_fire;
    logic             head_live;
    logic             head_done;
    logic             head_bad;
    logic [PC_W-1:0]  head_target;
    logic             wbq_live;

    rw_pointers #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (alloc_fire),
        .pop      (commit_valid),
        .flush    (redirect_valid),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .full     (full),
        .empty    (empty)
    );

    rw_slots #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .PC_W(PC_W)
    ) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_we    (alloc_fire),
        .alloc_slot  (tail_idx),
        .alloc_dest  (alloc_dest),
        .alloc_is_br (alloc_is_br),
        .wb_we       (wb_valid),
        .wb_slot     (wb_idx),
        .wb_value    (wb_value),
        .wb_bad      (wb_mispredict),
        .wb_target   (wb_target),
        .retire_we   (commit_valid),
        .retire_slot (head_idx),
        .flush       (redirect_valid),
        .head_slot   (head_idx),
        .head_live   (head_live),
        .head_done   (head_done),
        .head_bad    (head_bad),
        .head_dest   (commit_dest),
        .head_value  (commit_value),
        .head_target (head_target),
        .wbq_live    (wbq_live),
        .wbq_dest    (bcast_dest)
    );

    // Retirement, redirect, allocation handshake and result bus
    always_comb begin
        commit_valid   = head_live & head_done;
        redirect_valid = commit_valid & head_bad;
        redirect_pc    = head_target;
        alloc_ready    = ~full & ~redirect_valid;
        alloc_fire     = alloc_valid & alloc_ready;
        alloc_idx      = tail_idx;
        bcast_valid    = wb_valid & wbq_live;
        bcast_value    = wb_value;
    end

endmodule

// File: rtl/retire_window_chk.sv
// Checker for the retirement window, bound to every instance of the top.
// It watches the handshake, the pointer state and the redirect timing.
module retire_window_chk #(
    parameter int DEPTH = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      alloc_valid,
    input logic                      alloc_ready,
    input logic [$clog2(DEPTH)-1:0]  alloc_idx,
    input logic                      commit_valid,
    input logic                      redirect_valid,
    input logic                      full,
    input logic                      empty
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] ONE = 1;

    assert_empty_accepts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (alloc_ready && !commit_valid));

    assert_alloc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=> (alloc_idx - $past(alloc_idx)) == ONE);

    assert_alloc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(alloc_valid && alloc_ready) && !commit_valid) |=> $stable(alloc_idx));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_ready);

    assert_redirect_retires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (commit_valid && !alloc_ready));

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> empty);

endmodule

bind retire_window retire_window_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_valid    (alloc_valid),
    .alloc_ready    (alloc_ready),
    .alloc_idx      (alloc_idx),
    .commit_valid   (commit_valid),
    .redirect_valid (redirect_valid),
    .full           (full),
    .empty          (empty)
);

// File: tb/retire_window_bench.sv
module retire_window_bench;
    localparam int DEPTH  = 16;
    localparam int TAG_W  = 6;
    localparam int DATA_W = 32;
    localparam int PC_W   = 32;
    localparam int IDX_W  = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0;
    logic [TAG_W-1:0] alloc_dest = '0;
    logic alloc_is_br = 1'b0;
    logic alloc_ready;
    logic [IDX_W-1:0] alloc_idx;
    logic wb_valid = 1'b0;
    logic [IDX_W-1:0] wb_idx = '0;
    logic [DATA_W-1:0] wb_value = '0;
    logic wb_mispredict = 1'b0;
    logic [PC_W-1:0] wb_target = '0;
    logic bcast_valid;
    logic [TAG_W-1:0] bcast_dest;
    logic [DATA_W-1:0] bcast_value;
    logic commit_valid;
    logic [TAG_W-1:0] commit_dest;
    logic [DATA_W-1:0] commit_value;
    logic redirect_valid;
    logic [PC_W-1:0] redirect_pc;

    int n_checks = 0;
    int n_fail = 0;

    // Commit log captured away from the clock edge
    int log_n = 0;
    logic [TAG_W-1:0] log_dest [64];
    int redir_n = 0;
    logic [PC_W-1:0] redir_pc_seen = '0;

    always #5 clk = ~clk;

    retire_window #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_retire_window (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_dest(alloc_dest), .alloc_is_br(alloc_is_br),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_value(wb_value),
        .wb_mispredict(wb_mispredict), .wb_target(wb_target),
        .bcast_valid(bcast_valid), .bcast_dest(bcast_dest), .bcast_value(bcast_value),
        .commit_valid(commit_valid), .commit_dest(commit_dest), .commit_value(commit_value),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    always @(negedge clk) begin
        if (rst_n && commit_valid) begin
            if (log_n < 64) log_dest[log_n] = commit_dest;
            log_n = log_n + 1;
            if (redirect_valid) begin
                redir_n = redir_n + 1;
                redir_pc_seen = redirect_pc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        alloc_valid = 1'b0; alloc_is_br = 1'b0; wb_valid = 1'b0; wb_mispredict = 1'b0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        #1;
        log_n = 0; redir_n = 0;
    endtask

    task automatic put(input logic [TAG_W-1:0] d, input logic br);
        alloc_valid = 1'b1; alloc_dest = d; alloc_is_br = br;
        tick();
        alloc_valid = 1'b0; alloc_is_br = 1'b0;
    endtask

    task automatic wb_set(input int idx, input logic [DATA_W-1:0] v, input logic mp, input logic [PC_W-1:0] tgt);
        wb_valid = 1'b1; wb_idx = IDX_W'(idx); wb_value = v; wb_mispredict = mp; wb_target = tgt;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk(alloc_ready == 1'b1, "R1 alloc_ready", alloc_ready, 1);
        chk(alloc_idx == 0, "R1 alloc_idx", alloc_idx, 0);
        chk(commit_valid == 1'b0 && redirect_valid == 1'b0, "R1 commit/redirect idle",
            {commit_valid, redirect_valid}, 0);
    endtask

    task automatic t_out_of_order();
        do_reset();
        for (int i = 0; i < 4; i++) begin
            chk(alloc_idx == i, "R2 sequential alloc_idx", alloc_idx, i);
            put(TAG_W'(i + 1), 1'b0);
        end
        wb_set(2, 32'h22, 1'b0, '0);
        chk(bcast_valid && bcast_dest == 3 && bcast_value == 32'h22, "R5 broadcast",
            {bcast_valid, bcast_dest}, {1'b1, 6'd3});
        tick();
        wb_valid = 1'b0; #1;
        chk(commit_valid == 1'b0, "R4 younger done, head not done", commit_valid, 0);
        wb_set(0, 32'h20, 1'b0, '0);
        chk(commit_valid == 1'b0, "R4 no commit before write-back edge", commit_valid, 0);
        tick();
        chk(commit_valid && commit_dest == 1 && commit_value == 32'h20, "R4 head commit",
            commit_dest, 1);
        wb_set(3, 32'h23, 1'b0, '0);
        tick();
        wb_set(1, 32'h21, 1'b0, '0);
        tick();
        idle_inputs();
        for (int k = 0; k < 5; k++) tick();
        chk(log_n == 4, "R4 commit count", log_n, 4);
        for (int k = 0; k < 4; k++)
            chk(log_dest[k] == k + 1, "R4 commit order", log_dest[k], k + 1);
        chk(redir_n == 0, "R4 no redirect", redir_n, 0);
    endtask

    task automatic t_full_window();
        do_reset();
        for (int i = 0; i < DEPTH; i++) put(TAG_W'(i + 1), 1'b0);
        chk(alloc_ready == 1'b0, "R3 full stalls", alloc_ready, 0);
        alloc_valid = 1'b1; alloc_dest = 6'd63;
        tick();
        alloc_valid = 1'b0; #1;
        chk(alloc_idx == 0 && alloc_ready == 1'b0, "R3 refused alloc has no effect",
            {alloc_ready, alloc_idx}, 0);
        wb_set(0, 32'h100, 1'b0, '0);
        tick();
        wb_valid = 1'b0; #1;
        chk(commit_valid == 1'b1 && alloc_ready == 1'b0, "R9 retire from full keeps ready low",
            {commit_valid, alloc_ready}, 2'b10);
        tick();
        chk(alloc_ready == 1'b1 && alloc_idx == 0, "R9 slot freed next cycle",
            {alloc_ready, alloc_idx}, {1'b1, 4'd0});
        wb_set(1, 32'h101, 1'b0, '0);
        tick();
        wb_valid = 1'b0;
        alloc_valid = 1'b1; alloc_dest = 6'd40; #1;
        chk(commit_valid && alloc_ready, "R9 alloc and commit same cycle",
            {commit_valid, alloc_ready}, 2'b11);
        tick();
        alloc_valid = 1'b0; #1;
        chk(alloc_idx == 1 && alloc_ready == 1'b1, "R2 wrap of alloc_idx and R9 occupancy",
            {alloc_ready, alloc_idx}, {1'b1, 4'd1});
        for (int i = 2; i < DEPTH; i++) begin
            wb_set(i, 32'h100 + i, 1'b0, '0);
            tick();
        end
        wb_set(0, 32'h140, 1'b0, '0);
        tick();
        idle_inputs();
        for (int k = 0; k < DEPTH + 4; k++) tick();
        chk(log_n == DEPTH + 1, "R3 commit count after refused alloc", log_n, DEPTH + 1);
        for (int k = 0; k < DEPTH; k++)
            chk(log_dest[k] == k + 1, "R4 commit order in full window", log_dest[k], k + 1);
        chk(log_dest[DEPTH] == 40, "R9 wrapped entry commits last", log_dest[DEPTH], 40);
    endtask

    task automatic t_mispredict();
        do_reset();
        put(6'd5, 1'b0);
        put(6'd6, 1'b1);
        put(6'd7, 1'b0);
        put(6'd8, 1'b0);
        wb_set(2, 32'h7, 1'b0, '0); tick();
        wb_set(3, 32'h8, 1'b0, '0); tick();
        wb_set(0, 32'h5, 1'b0, '0); tick();
        wb_set(1, 32'h6, 1'b1, 32'h1234);
        chk(bcast_valid && bcast_dest == 6, "R5 branch broadcast", bcast_dest, 6);
        tick();
        wb_valid = 1'b0; wb_mispredict = 1'b0;
        alloc_valid = 1'b1; alloc_dest = 6'd50; #1;
        chk(commit_valid && commit_dest == 6 && redirect_valid, "R6 branch retires with redirect",
            {commit_valid, redirect_valid, commit_dest}, {2'b11, 6'd6});
        chk(redirect_pc == 32'h1234, "R6 redirect target", redirect_pc, 32'h1234);
        chk(alloc_ready == 1'b0, "R6 alloc blocked during redirect", alloc_ready, 0);
        tick();
        alloc_valid = 1'b0; #1;
        chk(commit_valid == 1'b0 && alloc_ready == 1'b1, "R6 window empty after flush",
            {commit_valid, alloc_ready}, 2'b01);
        chk(alloc_idx == 2, "R6 alloc_idx after flush", alloc_idx, 2);
        wb_set(2, 32'h77, 1'b0, '0);
        chk(bcast_valid == 1'b0, "R8 stale write-back not broadcast", bcast_valid, 0);
        tick();
        wb_valid = 1'b0; #1;
        chk(commit_valid == 1'b0, "R8 stale write-back no commit", commit_valid, 0);
        put(6'd9, 1'b0);
        wb_set(2, 32'h9, 1'b1, 32'hBEEF);
        tick();
        idle_inputs(); #1;
        chk(commit_valid && !redirect_valid && commit_dest == 9, "R10 flag on non-branch ignored",
            {commit_valid, redirect_valid}, 2'b10);
        tick(); tick();
        chk(log_n == 3 && log_dest[2] == 9, "R6 discarded entries never commit", log_n, 3);
        chk(redir_n == 1 && redir_pc_seen == 32'h1234, "R6 single redirect", redir_n, 1);
    endtask

    task automatic t_good_branch();
        do_reset();
        put(6'd11, 1'b1);
        put(6'd12, 1'b0);
        wb_set(1, 32'hC, 1'b0, '0); tick();
        wb_set(0, 32'hB, 1'b0, 32'h4444); tick();
        idle_inputs(); #1;
        chk(commit_valid && !redirect_valid && commit_dest == 11, "R7 good branch no redirect",
            {commit_valid, redirect_valid}, 2'b10);
        tick();
        chk(commit_valid && commit_dest == 12, "R7 younger entry commits", commit_dest, 12);
        tick(); tick();
        chk(log_n == 2 && redir_n == 0, "R7 commit count", log_n, 2);
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_out_of_order();
        t_full_window();
        t_mispredict();
        t_good_branch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule